// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns a 64-bit integer operand into a binary floating-point value. A two-bit kind input chooses signed or unsigned reading of the operand and a target precision of 53 or 24 significant bits. The result always comes out in the 64-bit double layout: 1 sign bit, 11 exponent bits biased by 1023, and 52 fraction bits. A single-precision result is rounded to 24 bits and then widened into that layout, so its low 29 fraction bits are zero. Rounding follows one of four modes picked by a two-bit mode input. Next to the result the block reports an increment flag (FR), an inexact flag (FI), a sticky inexact summary (XX) and a small result class.

The datapath takes the magnitude, finds the leading one and shifts it to the top. It then rounds at the kept width, and a carry out of the rounding add bumps the exponent. The whole datapath is combinational and feeds one result register. A two-state controller runs the handshake. In `ST_IDLE` the block raises `in_ready`. The transition `T_ACCEPT` (idle with `in_valid` high) captures the result and enters `ST_EMIT`. In `ST_EMIT`, `out_valid` is high for that one cycle, and the unconditional transition `T_RETURN` goes back to `ST_IDLE`. `in_valid` is ignored while in `ST_EMIT`.

Top module: `i2f_convert`

## Requirements
- R1: After reset the block is in ST_IDLE with in_ready=1, out_valid=0 and out_xx=0. An input taken in ST_IDLE raises out_valid for exactly one cycle, on the next clock, and in_ready is low during that cycle.
- R2: An all-zero operand yields out_result=0, out_fr=0, out_fi=0 and class 2'b00 (zero).
- R3: in_kind[1]=0 reads the operand as two's complement: the sign is bit 63 and the magnitude is its negation when that bit is set. in_kind[1]=1 reads it as unsigned with sign 0.
- R4: The exponent field (bits 62:52) is 1023 plus the bit index of the magnitude's leading one. The leading one is not stored, and the fraction field holds the bits below it, left-aligned.
- R5: in_kind[0]=1 rounds to 24 significant bits, with out_result[28:0]=0.
- R6: in_kind[0]=0 rounds to 53 significant bits.
- R7: in_rmode selects 2'b00 nearest-even, 2'b01 toward zero, 2'b10 toward +infinity, 2'b11 toward -infinity. The discarded bits decide the increment.
- R8: When rounding overflows the kept width, the exponent rises by one and the fraction field is zero.
- R9: out_fr is 1 exactly when the magnitude was incremented. out_fi is 1 exactly when any discarded bit was nonzero.
- R10: out_xx is the OR of out_fi over every conversion since reset.
- R11: Class is 2'b01 for a positive nonzero result and 2'b10 for a negative result.
- R12: The most-negative 64-bit integer converts exactly, as -2^63 (0xC3E0000000000000 for the double target).
- R13: in_valid in ST_EMIT is ignored: no second output and no change to out_result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Block can take an operand (ST_IDLE) |
| in_operand | input | 64 | Integer operand |
| in_kind | input | 2 | Bit 1: unsigned; bit 0: single-precision target |
| in_rmode | input | 2 | Rounding mode |
| out_valid | output | 1 | Result strobe, one cycle |
| out_result | output | 64 | Result in double layout |
| out_fr | output | 1 | Magnitude was rounded up |
| out_fi | output | 1 | Result inexact |
| out_xx | output | 1 | Sticky inexact since reset |
| out_class | output | 2 | 00 zero, 01 positive, 10 negative |

## Verification
Two events can land on one conversion: a rounding carry that renormalises the exponent, and the inexact and increment flags. Operands made of a run of ones wider than the kept width, such as 2^54-1 or all-ones under nearest-even or upward rounding, produce both at once. The bench model checks the exponent bump, the zero fraction and the flags together. The bench also holds in_valid high with different data through ST_EMIT, so that the handshake and the ignored input are tested in the same cycle as an output strobe.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
    localparam int XLEN     = 64;
    localparam int EXP_W    = 11;
    localparam int FRAC_W   = 52;
    localparam int EXP_BIAS = 1023;
    localparam int SGL_KEEP = 24;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'd0,
        RM_TO_ZERO   = 2'd1,
        RM_UP        = 2'd2,
        RM_DOWN      = 2'd3
    } rmode_e;

    typedef enum logic [1:0] {
        CL_ZERO = 2'd0,
        CL_POS  = 2'd1,
        CL_NEG  = 2'd2
    } class_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } state_e;
endpackage

// File: rtl/i2f_lead_find.sv
module i2f_lead_find #(
    parameter int W = 64,
    localparam int CW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] lead,
    output logic          none
);
    always_comb begin
        lead = '0;
        none = 1'b1;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                lead = CW'(i);
                none = 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2f_normalize.sv
module i2f_normalize #(
    parameter int W = 64,
    localparam int CW = $clog2(W)
) (
    input  logic [W-1:0]  operand,
    input  logic          as_signed,
    output logic          sign,
    output logic          zero,
    output logic [W-1:0]  norm,
    output logic [CW-1:0] lead
);
    logic [W-1:0] mag;

    always_comb begin
        sign = as_signed & operand[W-1];
        mag  = sign ? (~operand + 1'b1) : operand;
    end

    i2f_lead_find #(.W(W)) u_find (
        .vec  (mag),
        .lead (lead),
        .none (zero)
    );

    always_comb norm = mag << (CW'(W - 1) - lead);
endmodule

// File: rtl/i2f_round.sv
module i2f_round
    import i2f_pkg::*;
#(
    parameter int W    = 64,
    parameter int KEEP = 53,
    localparam int LOW = W - KEEP
) (
    input  logic [W-1:0]    norm,
    input  logic            sign,
    input  rmode_e          rmode,
    output logic [KEEP-2:0] mant,
    output logic            carry,
    output logic            hidden,
    output logic            fr,
    output logic            fi
);
    logic [KEEP-1:0] kept;
    logic            lsb, g_bit, r_bit, s_bit, inc;

    always_comb begin
        kept  = norm[W-1 -: KEEP];
        lsb   = kept[0];
        g_bit = norm[LOW-1];
        r_bit = norm[LOW-2];
        s_bit = |norm[LOW-3:0];
        fi    = g_bit | r_bit | s_bit;
        unique case (rmode)
            RM_NEAR_EVEN: inc = g_bit & (lsb | r_bit | s_bit);
            RM_TO_ZERO:   inc = 1'b0;
            RM_UP:        inc = fi & ~sign;
            RM_DOWN:      inc = fi & sign;
            default:      inc = 1'b0;
        endcase
        fr = inc;
        {carry, hidden, mant} = {1'b0, kept} + (KEEP + 1)'(inc);
    end
endmodule

// File: rtl/i2f_convert.sv
module i2f_convert
    import i2f_pkg::*;
#(
    parameter int XW    = XLEN,
    parameter int EW    = EXP_W,
    parameter int FW    = FRAC_W,
    parameter int BIAS  = EXP_BIAS,
    parameter int SKEEP = SGL_KEEP,
    localparam int RW   = 1 + EW + FW,
    localparam int CW   = $clog2(XW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [XW-1:0] in_operand,
    input  logic [1:0]    in_kind,
    input  logic [1:0]    in_rmode,
    output logic          out_valid,
    output logic [RW-1:0] out_result,
    output logic          out_fr,
    output logic          out_fi,
    output logic          out_xx,
    output logic [1:0]    out_class
);
    localparam int DKEEP = FW + 1;
    localparam int TAIL  = FW - (SKEEP - 1);

    state_e state, state_nx;
    logic   accept;

    logic          n_sign, n_zero;
    logic [XW-1:0] n_norm;
    logic [CW-1:0] n_lead;

    logic [SKEEP-2:0] s_mant;
    logic             s_carry, s_hidden, s_fr, s_fi;
    logic [DKEEP-2:0] d_mant;
    logic             d_carry, d_hidden, d_fr, d_fi;

    logic          want_single;
    logic [FW-1:0] frac_sel;
    logic          carry_sel, hidden_sel, fr_now, fi_now;
    logic [EW-1:0] exp_sel;
    rmode_e        rmode;

    logic [RW-1:0] res_q;
    logic          fr_q, fi_q, xx_q, single_q;
    class_e        cls_q;

    assign rmode       = rmode_e'(in_rmode);
    assign want_single = in_kind[0];

    i2f_normalize #(.W(XW)) u_norm (
        .operand   (in_operand),
        .as_signed (~in_kind[1]),
        .sign      (n_sign),
        .zero      (n_zero),
        .norm      (n_norm),
        .lead      (n_lead)
    );

    i2f_round #(.W(XW), .KEEP(SKEEP)) u_rnd_single (
        .norm (n_norm), .sign (n_sign), .rmode (rmode),
        .mant (s_mant), .carry (s_carry), .hidden (s_hidden),
        .fr (s_fr), .fi (s_fi)
    );

    i2f_round #(.W(XW), .KEEP(DKEEP)) u_rnd_double (
        .norm (n_norm), .sign (n_sign), .rmode (rmode),
        .mant (d_mant), .carry (d_carry), .hidden (d_hidden),
        .fr (d_fr), .fi (d_fi)
    );

    always_comb begin
        if (want_single) begin
            frac_sel   = {s_mant, TAIL'(0)};
            carry_sel  = s_carry;
            hidden_sel = s_hidden;
            fr_now     = s_fr & ~n_zero;
            fi_now     = s_fi & ~n_zero;
        end else begin
            frac_sel   = d_mant;
            carry_sel  = d_carry;
            hidden_sel = d_hidden;
            fr_now     = d_fr & ~n_zero;
            fi_now     = d_fi & ~n_zero;
        end
        exp_sel = EW'(BIAS) + EW'(n_lead) + EW'(carry_sel);
    end

    // handshake controller: next state
    always_comb begin
        accept = 1'b0;
        unique case (state)
            ST_IDLE: begin
                accept   = in_valid;
                state_nx = in_valid ? ST_EMIT : ST_IDLE;
            end
            ST_EMIT: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs and result register
    always_comb begin
        in_ready   = (state == ST_IDLE);
        out_valid  = (state == ST_EMIT);
        out_result = res_q;
        out_fr     = fr_q;
        out_fi     = fi_q;
        out_xx     = xx_q;
        out_class  = cls_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q    <= '0;
            fr_q     <= 1'b0;
            fi_q     <= 1'b0;
            xx_q     <= 1'b0;
            single_q <= 1'b0;
            cls_q    <= CL_ZERO;
        end else if (accept) begin
            res_q    <= n_zero ? '0 : {n_sign, exp_sel, frac_sel};
            fr_q     <= fr_now;
            fi_q     <= fi_now;
            xx_q     <= xx_q | fi_now;
            single_q <= want_single;
            cls_q    <= n_zero ? CL_ZERO : (n_sign ? CL_NEG : CL_POS);
        end
    end

    // R1
    accept_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
    // R1
    emit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // R13
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(out_result));
    // R10
    xx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_xx |=> out_xx);
    // R9
    fr_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fr) |-> out_fi);
    // R5
    single_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && single_q) |-> (out_result[TAIL-1:0] == '0));
    // R8
    carry_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !n_zero) |-> (carry_sel != hidden_sel));
    // R2
    zero_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == CL_ZERO) |-> (out_result == '0 && !out_fi && !out_fr));
endmodule

// File: tb/test_i2f_convert.sv
module test_i2f_convert;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_operand = '0;
    logic [1:0]  in_kind = '0;
    logic [1:0]  in_rmode = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_fr, out_fi, out_xx;
    logic [1:0]  out_class;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #10ns clk = ~clk;

    i2f_convert i_i2f_convert (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready),
        .in_operand (in_operand), .in_kind (in_kind), .in_rmode (in_rmode),
        .out_valid (out_valid), .out_result (out_result),
        .out_fr (out_fr), .out_fi (out_fi), .out_xx (out_xx),
        .out_class (out_class)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // behavioural reference: value-level rounding by right shift and remainder
    function automatic void model(input logic [63:0] op, input logic [1:0] kind,
                                  input logic [1:0] rm, output logic [63:0] res,
                                  output logic fr, output logic fi,
                                  output logic [1:0] cls);
        logic        sgn, inc;
        logic [63:0] mag, kept, rem, half, total, frac;
        int          p, kw, sh, lead, e;
        sgn = kind[1] ? 1'b0 : op[63];
        mag = sgn ? (~op + 64'd1) : op;
        if (op == 64'd0) begin
            res = '0; fr = 0; fi = 0; cls = 2'b00;
            return;
        end
        p = -1;
        for (int i = 0; i < 64; i++) if (mag[i]) p = i;
        kw = kind[0] ? 24 : 53;
        sh = (p >= kw) ? p - (kw - 1) : 0;
        kept = mag >> sh;
        rem  = (sh == 0) ? 64'd0 : (mag & ((64'd1 << sh) - 64'd1));
        half = (sh == 0) ? 64'd0 : (64'd1 << (sh - 1));
        fi = (rem != 0);
        case (rm)
            2'd0: inc = (rem > half) || (sh != 0 && rem == half && kept[0]);
            2'd1: inc = 0;
            2'd2: inc = fi && !sgn;
            default: inc = fi && sgn;
        endcase
        lead  = p - sh;
        total = kept + {63'd0, inc};
        if ((total >> (lead + 1)) != 0) begin
            e = p + 1;
            frac = 0;
        end else begin
            e = p;
            frac = (total - (64'd1 << lead)) << (52 - lead);
        end
        res = {sgn, 11'(e + 1023), frac[51:0]};
        fr  = inc;
        cls = sgn ? 2'b10 : 2'b01;
    endfunction

    logic        m_busy = 0, m_have = 0, m_xx = 0, m_fr = 0, m_fi = 0;
    logic [63:0] m_res = '0;
    logic [1:0]  m_cls = '0;
    logic [63:0] t_res;
    logic        t_fr, t_fi;
    logic [1:0]  t_cls;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_busy <= 0; m_have <= 0; m_xx <= 0;
        end else if (m_busy) begin
            m_busy <= 0;                       // R13: input ignored while emitting
        end else if (in_valid) begin
            model(in_operand, in_kind, in_rmode, t_res, t_fr, t_fi, t_cls);
            m_busy <= 1; m_have <= 1;
            m_res <= t_res; m_fr <= t_fr; m_fi <= t_fi; m_cls <= t_cls;
            m_xx <= m_xx | t_fi;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1", "in_ready", {63'd0, in_ready}, {63'd0, !m_busy});
            chk("R1", "out_valid", {63'd0, out_valid}, {63'd0, m_busy});
            chk("R10", "out_xx", {63'd0, out_xx}, {63'd0, m_xx});
            if (m_have) chk("R4", "out_result", out_result, m_res);
            if (m_busy) begin
                chk("R9", "out_fr", {63'd0, out_fr}, {63'd0, m_fr});
                chk("R9", "out_fi", {63'd0, out_fi}, {63'd0, m_fi});
                chk("R11", "out_class", {62'd0, out_class}, {62'd0, m_cls});
            end
        end
    end

    task automatic issue(input logic [63:0] op, input logic [1:0] kind,
                         input logic [1:0] rm, input bit junk);
        @(negedge clk);
        in_valid = 1; in_operand = op; in_kind = kind; in_rmode = rm;
        @(negedge clk);
        if (junk) begin
            in_operand = ~op; in_kind = ~kind;   // R13: offered during ST_EMIT
        end else in_valid = 0;
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 / R10 reset state
        chk("R1", "reset in_ready", {63'd0, in_ready}, 64'd1);
        chk("R1", "reset out_valid", {63'd0, out_valid}, 64'd0);
        chk("R10", "reset out_xx", {63'd0, out_xx}, 64'd0);
        rst_n = 1;
        // R2 zero operand, both precisions
        issue(64'd0, 2'b00, 2'd0, 0);
        issue(64'd0, 2'b11, 2'd2, 0);
        // R3 R5: signed 7 and -32 to single
        issue(64'd7, 2'b01, 2'd0, 0);
        @(negedge clk);
        chk("R5", "seven single", out_result, 64'h401C000000000000);
        issue(-64'sd32, 2'b01, 2'd0, 0);
        @(negedge clk);
        chk("R3", "minus32 single", out_result, 64'hC040000000000000);
        // R12 most-negative integer
        issue(64'h8000000000000000, 2'b00, 2'd0, 0);
        @(negedge clk);
        chk("R12", "min int double", out_result, 64'hC3E0000000000000);
        // R3 same pattern read unsigned
        issue(64'h8000000000000000, 2'b10, 2'd0, 0);
        // R7 R6 tie cases in every mode
        for (int m = 0; m < 4; m++) begin
            issue(64'h0020000000000001, 2'b10, 2'(m), 0);
            issue(64'h003FFFFFFFFFFFFF, 2'b10, 2'(m), 0);
            issue(64'h0000000003000001, 2'b01, 2'(m), 0);
            issue(-64'sd123456789012345, 2'b00, 2'(m), 0);
            issue(-64'sd16777217, 2'b01, 2'(m), 0);
        end
        // R8 carry: all ones unsigned to double, nearest-even
        issue(64'hFFFFFFFFFFFFFFFF, 2'b10, 2'd0, 0);
        @(negedge clk);
        chk("R8", "all ones carry", out_result, 64'h43F0000000000000);
        issue(64'h00000000FFFFFFFF, 2'b11, 2'd2, 0);
        // R13 input held through ST_EMIT with other data
        issue(64'd1000001, 2'b00, 2'd1, 1);
        issue(64'hDEADBEEF12345678, 2'b01, 2'd3, 1);
        // mixed patterns across all kinds and modes
        for (int k = 0; k < 400; k++) begin
            logic [63:0] v;
            v = {$urandom, $urandom} >> ($urandom % 64);
            issue(v, 2'($urandom), 2'($urandom), ($urandom % 4) == 0);
        end
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule